// File: doc/BRIEF.md
# Serial Configuration Register Bank with Diagnostic Readback

This block is a serial-port slave that holds a small bank of 8-bit configuration registers for a data converter. A host drives a chip-select (`sen_n`, active low), a serial clock (`sclk`) and a serial data line (`sdata`). Each frame carries an address byte followed by a data byte. The block runs on a fast system clock. It synchronises the three serial pins and detects the `sclk` rising edges, so the serial clock must be several times slower than `clk`. The register contents are exported in parallel on `cfg_q` for the converter logic.

In normal mode a complete frame writes the data byte into the addressed register when `sen_n` is released. Register 00h is the control register. Setting its READOUT bit switches the bank into a diagnostic readback mode. In that mode every write except a write to 00h is blocked. During the data phase of each frame, the addressed register is shifted out MSB first on the tri-state `sdout` pin, so the host can check that the serial link works. Register 00h itself never reads back. Its RESET bit returns the whole bank to zero.

The frame decoder is a state machine with these states:
- S_IDLE: waiting for a frame.
- S_ADDR: shifting in the address bits.
- S_DATA: shifting in the data bits and, in readback mode, shifting the register out.
- S_FULL: exactly 16 bits have arrived.
- S_DROP: a surplus clock edge has arrived.

The transitions are:
- start (S_IDLE to S_ADDR): `sen_n` falls.
- addr_done (S_ADDR to S_DATA): the 8th rising edge.
- data_done (S_DATA to S_FULL): the 16th rising edge.
- overrun (S_FULL to S_DROP): a 17th rising edge.
- commit (S_FULL to S_IDLE): `sen_n` rises after exactly 16 bits.
- abort (S_ADDR, S_DATA or S_DROP to S_IDLE): `sen_n` rises at any other point.

Top module: `cfg_spi_bank`

## Requirements
- R1: A frame is 16 `sclk` rising edges while `sen_n` is low. The address byte comes first, MSB first, and `sdata` is sampled on rising edges. When `sen_n` rises after such a frame in normal mode, register n takes the data byte. Register n is visible on `cfg_q[8n+7:8n]`.
- R2: A frame with fewer or more than 16 rising edges changes no register.
- R3: While the READOUT bit (bit 0 of register 00h) is 1, frames addressed to registers 01h..07h leave those registers unchanged.
- R4: In readback mode, the addressed register appears on `sdout` MSB first during the data phase. Each bit is updated after an `sclk` rising edge and is held until the next rising edge, so it is valid at the falling edge in between.
- R5: In readback mode, frames addressed to 00h or to any unimplemented address (08h..FFh) shift out 00h.
- R6: While READOUT is 0, `sdout_oe` is low and `sdout` is high impedance.
- R7: In readback mode, `sdout_oe` is low during the address phase and while `sen_n` is high, and it is high for the whole data phase.
- R8: A frame that writes 00h with bit 0 clear ends readback mode, and later frames write registers normally again.
- R9: Writing 1 to the RESET bit (bit 1 of 00h) clears every register to 00h one clock after the bit is set, and the RESET bit itself clears with them.
- R10: Frames addressed to 08h..FFh change no register.
- R11: After `rst_n`, all registers are 00h and `sdout_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| sen_n | input | 1 | Serial frame select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdata | input | 1 | Serial data in, sampled on `sclk` rising edges |
| sdout | output | 1 | Tri-state serial readback data |
| sdout_oe | output | 1 | High while `sdout` is driven |
| cfg_q | output | 64 | All registers in parallel, register n in bits [8n+7:8n] |

## Verification
The bound checker watches several properties on every clock cycle:
- `sdout_oe` never rises without READOUT set, or while `sen_n` has been high for several cycles.
- The driven `sdout` bit moves only on a detected `sclk` rising edge.
- The upper registers stay frozen while readback mode is active.
- The RESET bit is followed by an all-zero bank on the next cycle.

Only the bench scenarios can show the rest: that the right byte lands in the right register, that the shifted-out bits are the addressed register in MSB-first order, that short and long frames are discarded, and that 00h and unimplemented addresses read back as zero.

// File: rtl/cfg_spi_pkg.sv
`timescale 1ns/1ps
package cfg_spi_pkg;
    localparam int CFG_AW   = 8;
    localparam int CFG_DW   = 8;
    localparam int CFG_NREG = 8;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_ADDR = 3'd1,
        S_DATA = 3'd2,
        S_FULL = 3'd3,
        S_DROP = 3'd4
    } frame_st_e;
endpackage

// File: rtl/cfg_spi_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for asynchronous serial pins.
module cfg_spi_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cfg_spi_frame_fsm.sv
`timescale 1ns/1ps
// Frame decoder: counts sclk rising edges and collects address and data.
module cfg_spi_frame_fsm
    import cfg_spi_pkg::*;
#(
    parameter int AW = CFG_AW,
    parameter int DW = CFG_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sen_act,
    input  logic          sclk_s,
    input  logic          sdata_s,
    output logic          sclk_rise,
    output logic          addr_done,
    output logic [AW-1:0] addr_now,
    output logic          data_shift,
    output logic          in_data,
    output logic          commit,
    output logic [AW-1:0] fr_addr,
    output logic [DW-1:0] fr_data
);
    localparam int FW = AW + DW;
    localparam int CW = $clog2(FW + 1);

    frame_st_e       st, st_nx;
    logic            sclk_d;
    logic [CW-1:0]   cnt;
    logic [FW-1:0]   sr;
    logic            last_addr, last_data;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign last_addr = (cnt == CW'(AW - 1));
    assign last_data = (cnt == CW'(FW - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: if (sen_act) st_nx = S_ADDR;
            S_ADDR: begin
                if (!sen_act)                    st_nx = S_IDLE;
                else if (sclk_rise && last_addr) st_nx = S_DATA;
            end
            S_DATA: begin
                if (!sen_act)                    st_nx = S_IDLE;
                else if (sclk_rise && last_data) st_nx = S_FULL;
            end
            S_FULL: begin
                if (!sen_act)       st_nx = S_IDLE;
                else if (sclk_rise) st_nx = S_DROP;
            end
            S_DROP: if (!sen_act) st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // Shift path and edge detector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cnt    <= '0;
            sr     <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (st == S_IDLE) begin
                cnt <= '0;
            end else if (sclk_rise && (st == S_ADDR || st == S_DATA)) begin
                cnt <= cnt + 1'b1;
                sr  <= {sr[FW-2:0], sdata_s};
            end
        end
    end

    // Outputs
    always_comb begin
        addr_done  = (st == S_ADDR) && sen_act && sclk_rise && last_addr;
        data_shift = (st == S_DATA) && sen_act && sclk_rise;
        in_data    = (st == S_DATA);
        commit     = (st == S_FULL) && !sen_act;
        addr_now   = {sr[AW-2:0], sdata_s};
        fr_addr    = sr[FW-1:DW];
        fr_data    = sr[DW-1:0];
    end
endmodule

// File: rtl/cfg_spi_regfile.sv
`timescale 1ns/1ps
// Register bank with readout lockout and self-clearing soft reset.
module cfg_spi_regfile
    import cfg_spi_pkg::*;
#(
    parameter int AW      = CFG_AW,
    parameter int DW      = CFG_DW,
    parameter int NREG    = CFG_NREG,
    parameter int RD_BIT  = 0,
    parameter int RST_BIT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic             readout,
    output logic [NREG*DW-1:0] cfg_q
);
    logic [DW-1:0] regs [NREG];

    assign readout = regs[0][RD_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (regs[0][RST_BIT]) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NREG; i++) begin
                if (wr_addr == AW'(i) && (i == 0 || !readout))
                    regs[i] <= wr_data;
            end
        end
    end

    // Register 0 and unimplemented addresses read as zero
    always_comb begin
        rd_data = '0;
        for (int i = 1; i < NREG; i++) begin
            if (rd_addr == AW'(i)) rd_data = regs[i];
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign cfg_q[g*DW +: DW] = regs[g];
    end
endmodule

// File: rtl/cfg_spi_readback.sv
`timescale 1ns/1ps
// Readback shifter driving the serial output.
module cfg_spi_readback #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          shift,
    input  logic          active,
    output logic          sd_bit,
    output logic          sd_oe
);
    logic [DW-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      shreg <= '0;
        else if (load)   shreg <= load_val;
        else if (shift)  shreg <= {shreg[DW-2:0], 1'b0};
    end

    assign sd_bit = shreg[DW-1];
    assign sd_oe  = active;
endmodule

// File: rtl/cfg_spi_bank.sv
`timescale 1ns/1ps
// Top: serial configuration bank with diagnostic readback.
module cfg_spi_bank
    import cfg_spi_pkg::*;
#(
    parameter int AW      = CFG_AW,
    parameter int DW      = CFG_DW,
    parameter int NREG    = CFG_NREG,
    parameter int RD_BIT  = 0,
    parameter int RST_BIT = 1,
    parameter int SYNC    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sen_n,
    input  logic               sclk,
    input  logic               sdata,
    output logic               sdout,
    output logic               sdout_oe,
    output logic [NREG*DW-1:0] cfg_q
);
    logic          sen_s, sclk_s, sdata_s;
    logic          sclk_rise, addr_done, data_shift, in_data, commit;
    logic [AW-1:0] addr_now, fr_addr;
    logic [DW-1:0] fr_data, rd_data;
    logic          readout, sdout_d;

    cfg_spi_sync #(.W(3), .STAGES(SYNC), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sen_n, sclk, sdata}),
        .q     ({sen_s, sclk_s, sdata_s})
    );

    cfg_spi_frame_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sen_act    (~sen_s),
        .sclk_s     (sclk_s),
        .sdata_s    (sdata_s),
        .sclk_rise  (sclk_rise),
        .addr_done  (addr_done),
        .addr_now   (addr_now),
        .data_shift (data_shift),
        .in_data    (in_data),
        .commit     (commit),
        .fr_addr    (fr_addr),
        .fr_data    (fr_data)
    );

    cfg_spi_regfile #(.AW(AW), .DW(DW), .NREG(NREG), .RD_BIT(RD_BIT), .RST_BIT(RST_BIT)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .wr_addr (fr_addr),
        .wr_data (fr_data),
        .rd_addr (addr_now),
        .rd_data (rd_data),
        .readout (readout),
        .cfg_q   (cfg_q)
    );

    cfg_spi_readback #(.DW(DW)) u_rb (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (addr_done),
        .load_val (rd_data),
        .shift    (data_shift),
        .active   (in_data & readout),
        .sd_bit   (sdout_d),
        .sd_oe    (sdout_oe)
    );

    assign sdout = sdout_oe ? sdout_d : 1'bz;
endmodule

// File: rtl/cfg_spi_bank_chk.sv
`timescale 1ns/1ps
// Property checker bound to cfg_spi_bank.
module cfg_spi_bank_chk #(
    parameter int DW      = 8,
    parameter int NREG    = 8,
    parameter int RD_BIT  = 0,
    parameter int RST_BIT = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sen_n,
    input logic               sdout_oe,
    input logic               sdout_d,
    input logic               sclk_rise,
    input logic [NREG*DW-1:0] cfg_q
);
    // R6: output enable requires readback mode
    a_r6_oe_needs_readout: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[RD_BIT] |-> !sdout_oe);

    // R7: output released once the select has been high for a while
    a_r7_oe_off_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (sen_n && $past(sen_n) && $past(sen_n, 2) && $past(sen_n, 3)) |-> !sdout_oe);

    // R4: driven bit changes only after a detected sclk rising edge
    a_r4_bit_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (sdout_oe && $past(sdout_oe) && !$past(sclk_rise)) |-> $stable(sdout_d));

    // R3: upper registers frozen in readback mode
    a_r3_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[RD_BIT] && !cfg_q[RST_BIT]) |=> $stable(cfg_q[NREG*DW-1:DW]));

    // R9: soft reset clears the bank one cycle later
    a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[RST_BIT] |=> (cfg_q == '0));
endmodule

bind cfg_spi_bank cfg_spi_bank_chk #(
    .DW(DW), .NREG(NREG), .RD_BIT(RD_BIT), .RST_BIT(RST_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sen_n     (sen_n),
    .sdout_oe  (sdout_oe),
    .sdout_d   (sdout_d),
    .sclk_rise (sclk_rise),
    .cfg_q     (cfg_q)
);

// File: tb/cfg_spi_bank_tb.sv
`timescale 1ns/1ps
module cfg_spi_bank_tb;
    localparam int HP = 8;   // sclk half period in clk cycles

    typedef struct packed {
        logic       rd;      // 1: readback check, 0: register check
        logic       ro;      // readback mode active during this frame
        logic [7:0] addr;
        logic [7:0] data;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{1'b0, 1'b0, 8'h01, 8'hA5, 8'hA5},
        '{1'b0, 1'b0, 8'h02, 8'h3C, 8'h3C},
        '{1'b0, 1'b0, 8'h07, 8'h81, 8'h81},
        '{1'b0, 1'b0, 8'h00, 8'h01, 8'h01},
        '{1'b1, 1'b1, 8'h01, 8'h00, 8'hA5},
        '{1'b1, 1'b1, 8'h07, 8'h00, 8'h81},
        '{1'b0, 1'b1, 8'h02, 8'h77, 8'h3C},
        '{1'b1, 1'b1, 8'h02, 8'h00, 8'h3C},
        '{1'b1, 1'b1, 8'h00, 8'h01, 8'h00},
        '{1'b1, 1'b1, 8'h0C, 8'h00, 8'h00},
        '{1'b0, 1'b1, 8'h00, 8'h00, 8'h00},
        '{1'b0, 1'b0, 8'h02, 8'h77, 8'h77}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sen_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdata = 1'b0;
    wire         sdout;
    logic        sdout_oe;
    logic [63:0] cfg_q;

    int   n_checks = 0;
    int   n_errors = 0;
    logic done = 1'b0;

    logic [7:0] cap;
    logic       oe_addr, oe_any, oe_all;

    always #5 clk = ~clk;

    cfg_spi_bank u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sen_n    (sen_n),
        .sclk     (sclk),
        .sdata    (sdata),
        .sdout    (sdout),
        .sdout_oe (sdout_oe),
        .cfg_q    (cfg_q)
    );

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] a, input logic [7:0] d, input int nbits);
        logic [15:0] bits;
        bits    = {a, d};
        cap     = 8'h00;
        oe_addr = 1'b0;
        oe_any  = 1'b0;
        oe_all  = 1'b1;
        sen_n   = 1'b0;
        wait_clks(HP);
        for (int i = 0; i < nbits; i++) begin
            sdata = (i < 16) ? bits[15-i] : 1'b0;
            wait_clks(HP);
            if (i < 8) oe_addr = oe_addr | sdout_oe;
            if (i >= 8 && i < 16) begin
                cap[15-i] = sdout;
                oe_any    = oe_any | sdout_oe;
                oe_all    = oe_all & sdout_oe;
            end
            sclk = 1'b1;
            wait_clks(HP);
            sclk = 1'b0;
        end
        wait_clks(HP);
        sen_n = 1'b1;
        wait_clks(12);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        wait_clks(4);
        chk("R11 bank after reset", cfg_q, 64'h0);
        chk("R11 oe after reset", {63'h0, sdout_oe}, 64'h0);
        rst_n = 1'b1;
        wait_clks(4);

        // Table: R1 writes, R3 lockout, R4/R5 readback, R6/R7 enable, R8 exit
        for (int k = 0; k < 12; k++) begin
            send(VEC[k].addr, VEC[k].data, 16);
            if (VEC[k].rd) begin
                chk("R4 R5 readback byte", {56'h0, cap}, {56'h0, VEC[k].exp});
                chk("R7 oe in data phase", {63'h0, oe_all}, 64'h1);
                chk("R7 oe in address phase", {63'h0, oe_addr}, 64'h0);
            end else begin
                chk("R1 R3 R8 register value", {56'h0, cfg_q[VEC[k].addr[2:0]*8 +: 8]},
                    {56'h0, VEC[k].exp});
                if (!VEC[k].ro)
                    chk("R6 oe while readout off", {62'h0, oe_addr, oe_any}, 64'h0);
            end
        end

        // Bank now: r1=A5 r2=77 r7=81, readback off
        send(8'h01, 8'h5A, 12);
        chk("R2 short frame discarded", cfg_q, 64'h8100_0000_0077_A500);
        send(8'h01, 8'h5A, 17);
        chk("R2 long frame discarded", cfg_q, 64'h8100_0000_0077_A500);
        send(8'h0B, 8'h33, 16);
        chk("R10 unimplemented write ignored", cfg_q, 64'h8100_0000_0077_A500);

        // Readback mode, idle select
        send(8'h00, 8'h01, 16);
        wait_clks(20);
        chk("R7 oe low while select high", {63'h0, sdout_oe}, 64'h0);
        send(8'hFF, 8'h01, 16);
        chk("R5 top address reads zero", {56'h0, cap}, 64'h0);
        chk("R7 oe through data phase", {63'h0, oe_all}, 64'h1);

        // Soft reset
        send(8'h00, 8'h02, 16);
        chk("R9 soft reset clears bank", cfg_q, 64'h0);
        send(8'h05, 8'hC3, 16);
        chk("R9 writes after reset", cfg_q, 64'h0000_C300_0000_0000);
        chk("R6 oe low after reset", {63'h0, sdout_oe}, 64'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule